// File: doc/BRIEF.md
# Indirect PHY Register Access Port

This block gives a host bus one 32-bit control word through which it reaches a bank of 8-bit PHY delay registers. The host cannot write a PHY register directly. It loads an address and a data byte into the control word. It then writes the same word again with a request bit set. The block raises an acknowledge flag in that same word after a programmable number of clock cycles. The host then clears the request, and the block drops the acknowledge. A read request works the same way. It returns the addressed byte in a read-data field of the word.

The PHY side is modelled by a 64-entry by 8-bit register bank. In a typical setup, software writes the per-speed-mode input delays at addresses 0x00 to 0x08 and the clock and strobe DLL delays at 0x0B to 0x0D, one handshake per byte. Software polls for the acknowledge and gives up after a bounded time. The acknowledge delay is a parameter, so the time the host waits is set at build time. A request withdrawn before the acknowledge cancels the operation.

Top module: `phy_acc_port`

## Requirements
- R1: After reset the control word reads 0x0000_0000 and every bank entry reads back as 0x00.
- R2: The control word reads back the fields the host last wrote: address in bits [5:0], write data in bits [15:8], write request in bit 24 and read request in bit 25. Bits [23:16] hold the last byte read and bit 26 is the acknowledge. Bits [7:6] and [31:27] always read 0, whatever the host wrote to them.
- R3: When a bus write raises a request, the acknowledge (bit 26) rises exactly ACK_DLY+1 cycles after that write's clock edge. It stays high for as long as a request bit is held.
- R4: A write request (bit 24) stores the data byte into the bank entry at the address, in the cycle the acknowledge rises.
- R5: A read request (bit 25) places the addressed bank entry in bits [23:16] when the acknowledge rises. That field changes at no other time.
- R6: Once the host clears both request bits, the acknowledge falls on the next clock edge.
- R7: Address and data are taken when the request starts. Rewriting them while the request is held changes neither the entry written nor its value.
- R8: A request withdrawn before the acknowledge rises is abandoned. The acknowledge stays low and the bank is unchanged.
- R9: With both request bits set, the operation is a write, and bits [23:16] keep their previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cw_we | input | 1 | Host write strobe for the control word |
| cw_wdata | input | 32 | Control word value written by the host |
| cw_rdata | output | 32 | Current control word as read by the host |

## Verification
The properties assume that the request bits change only through whole-word host writes. They also assume that the host never raises a new request until it has seen the acknowledge fall. The acknowledge and read-data rules are checked only against the request bits shown in the same readback word. The stimulus always clears the request after the acknowledge and waits for the acknowledge to drop before the next operation. The one exception is the deliberate early withdrawal, which still clears the request before any acknowledge can appear. Rewriting fields during a pending operation always keeps the write request bit set, so that case never looks like a new request.

// File: rtl/phy_acc_pkg.sv
package phy_acc_pkg;
   // Bit positions inside the host control word; software decodes these.
   parameter int unsigned ADDR_LSB  = 0;
   parameter int unsigned WDATA_LSB = 8;
   parameter int unsigned RDATA_LSB = 16;
   parameter int unsigned WREQ_BIT  = 24;
   parameter int unsigned RREQ_BIT  = 25;
   parameter int unsigned ACK_BIT   = 26;
   parameter int unsigned MAX_ADDR_W = 6;
   parameter int unsigned MAX_DATA_W = 8;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_DONE = 2'd2
   } hs_state_t;
endpackage

// File: rtl/phy_acc_ctrl.sv
module phy_acc_ctrl
   import phy_acc_pkg::*;
#(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [31:0]       wdata,
   output logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] data,
   output logic              wreq,
   output logic              rreq
);
   // Host-writable part of the control word; other bits are dropped.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr <= '0;
         data <= '0;
         wreq <= 1'b0;
         rreq <= 1'b0;
      end else if (we) begin
         addr <= wdata[ADDR_LSB +: ADDR_W];
         data <= wdata[WDATA_LSB +: DATA_W];
         wreq <= wdata[WREQ_BIT];
         rreq <= wdata[RREQ_BIT];
      end
   end
endmodule

// File: rtl/phy_acc_hs.sv
module phy_acc_hs
   import phy_acc_pkg::*;
#(
   parameter int unsigned ACK_DLY = 4,
   parameter int unsigned ADDR_W  = 6,
   parameter int unsigned DATA_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wreq,
   input  logic              rreq,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_data,
   input  logic [DATA_W-1:0] bank_rdata,
   output logic              ack,
   output logic              bank_we,
   output logic [ADDR_W-1:0] op_addr,
   output logic [DATA_W-1:0] op_data,
   output logic [DATA_W-1:0] rd_byte
);
   localparam bit SKIP = (ACK_DLY == 0);

   hs_state_t         st;
   logic              req;
   logic              lat_wr;
   logic [ADDR_W-1:0] lat_addr;
   logic [DATA_W-1:0] lat_data;
   logic              op_wr;
   logic              cnt_done;
   logic              commit;

   assign req = wreq | rreq;

   // Delay variant: zero delay completes from idle using live fields.
   if (SKIP) begin : g_nowait
      assign cnt_done = 1'b1;
      always_comb begin
         op_addr = req_addr;
         op_data = req_data;
         op_wr   = wreq;
         commit  = (st == ST_IDLE) && req;
      end
   end else begin : g_cnt
      localparam int unsigned CNT_W = (ACK_DLY > 1) ? $clog2(ACK_DLY) : 1;
      logic [CNT_W-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cnt <= '0;
         else if (st != ST_WAIT)
            cnt <= '0;
         else if (!cnt_done)
            cnt <= cnt + 1'b1;
      end
      assign cnt_done = (cnt == CNT_W'(ACK_DLY - 1));
      always_comb begin
         op_addr = lat_addr;
         op_data = lat_data;
         op_wr   = lat_wr;
         commit  = (st == ST_WAIT) && req && cnt_done;
      end
   end

   assign bank_we = commit && op_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         ack      <= 1'b0;
         lat_wr   <= 1'b0;
         lat_addr <= '0;
         lat_data <= '0;
         rd_byte  <= '0;
      end else begin
         case (st)
            ST_IDLE: if (req) begin
               lat_addr <= req_addr;
               lat_data <= req_data;
               lat_wr   <= wreq;
               if (SKIP) begin
                  ack <= 1'b1;
                  st  <= ST_DONE;
               end else begin
                  st  <= ST_WAIT;
               end
            end
            ST_WAIT: if (!req) begin
               st <= ST_IDLE;
            end else if (cnt_done) begin
               ack <= 1'b1;
               st  <= ST_DONE;
            end
            ST_DONE: if (!req) begin
               ack <= 1'b0;
               st  <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
         if (commit && !op_wr)
            rd_byte <= bank_rdata;
      end
   end
endmodule

// File: rtl/phy_acc_bank.sv
module phy_acc_bank #(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++)
            mem[i] <= '0;
      end else if (we) begin
         mem[addr] <= wdata;
      end
   end

   assign rdata = mem[addr];
endmodule

// File: rtl/phy_acc_port.sv
module phy_acc_port
   import phy_acc_pkg::*;
#(
   parameter int unsigned ADDR_W  = 6,
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned ACK_DLY = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cw_we,
   input  logic [31:0] cw_wdata,
   output logic [31:0] cw_rdata
);
   if (ADDR_W < 1 || ADDR_W > MAX_ADDR_W) begin : g_bad_addr_w
      $error("phy_acc_port: ADDR_W must lie in 1..6");
   end
   if (DATA_W < 1 || DATA_W > MAX_DATA_W) begin : g_bad_data_w
      $error("phy_acc_port: DATA_W must lie in 1..8");
   end

   logic [ADDR_W-1:0] fld_addr;
   logic [DATA_W-1:0] fld_data;
   logic              wreq;
   logic              rreq;
   logic              ack;
   logic              bank_we;
   logic [ADDR_W-1:0] op_addr;
   logic [DATA_W-1:0] op_data;
   logic [DATA_W-1:0] bank_rdata;
   logic [DATA_W-1:0] rd_byte;

   phy_acc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cw_we),
      .wdata (cw_wdata),
      .addr  (fld_addr),
      .data  (fld_data),
      .wreq  (wreq),
      .rreq  (rreq)
   );

   phy_acc_hs #(.ACK_DLY(ACK_DLY), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wreq       (wreq),
      .rreq       (rreq),
      .req_addr   (fld_addr),
      .req_data   (fld_data),
      .bank_rdata (bank_rdata),
      .ack        (ack),
      .bank_we    (bank_we),
      .op_addr    (op_addr),
      .op_data    (op_data),
      .rd_byte    (rd_byte)
   );

   phy_acc_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (bank_we),
      .addr  (op_addr),
      .wdata (op_data),
      .rdata (bank_rdata)
   );

   always_comb begin
      cw_rdata                         = '0;
      cw_rdata[ADDR_LSB  +: ADDR_W]    = fld_addr;
      cw_rdata[WDATA_LSB +: DATA_W]    = fld_data;
      cw_rdata[RDATA_LSB +: DATA_W]    = rd_byte;
      cw_rdata[WREQ_BIT]               = wreq;
      cw_rdata[RREQ_BIT]               = rreq;
      cw_rdata[ACK_BIT]                = ack;
   end
endmodule

// File: rtl/phy_acc_port_chk.sv
module phy_acc_port_chk
   import phy_acc_pkg::*;
#(
   parameter int unsigned ADDR_W = 6
) (
   input logic        clk,
   input logic        rst_n,
   input logic [31:0] cw_rdata
);
   localparam logic [31:0] RSVD_MASK =
      32'hF800_0000 | (32'h0000_00FF & ~((32'h1 << ADDR_W) - 32'h1));

   logic ack_s;
   logic req_s;
   assign ack_s = cw_rdata[ACK_BIT];
   assign req_s = cw_rdata[WREQ_BIT] | cw_rdata[RREQ_BIT];

   // R2: unused bits never read as 1
   p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cw_rdata & RSVD_MASK) == 32'h0);

   // R3: acknowledge held while a request is held
   p_ack_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_s && req_s) |=> ack_s);

   // R3: acknowledge rises only after a cycle with a request present
   p_ack_rise_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_s) |-> $past(req_s));

   // R5: read-data field moves only when acknowledge rises
   p_rd_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(ack_s) |-> $stable(cw_rdata[RDATA_LSB +: 8]));

   // R6: acknowledge falls one edge after the request is gone
   p_ack_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_s && !req_s) |=> !ack_s);

   // R8: no acknowledge appears without a request
   p_no_ack_unreq_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!ack_s && !req_s) |=> !ack_s);
endmodule

bind phy_acc_port phy_acc_port_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cw_rdata (cw_rdata)
);

// File: tb/phy_acc_port_test.sv
`timescale 1ns/1ps
module phy_acc_port_test;
   localparam int unsigned ACK = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cw_we = 1'b0;
   logic [31:0] cw_wdata = '0;
   logic [31:0] cw_rdata;

   always #2 clk = ~clk;   // 250 MHz

   phy_acc_port #(.ADDR_W(6), .DATA_W(8), .ACK_DLY(ACK)) uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .cw_we    (cw_we),
      .cw_wdata (cw_wdata),
      .cw_rdata (cw_rdata)
   );

   typedef struct {
      bit         is_rd;
      logic [7:0] exp;
      int         exp_cyc;
      string      tag;
   } item_t;

   item_t      sbq[$];
   item_t      mon_it;
   logic [7:0] model [64];
   logic [7:0] last_rd;
   int         checks = 0;
   int         fails = 0;
   int         cyc = 0;
   logic       prev_ack = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   function automatic logic [31:0] word(bit wr, bit rd, logic [5:0] a, logic [7:0] d);
      return {5'b0, 1'b0, rd, wr, 8'h00, d, 2'b00, a};
   endfunction

   task automatic bus_wr(logic [31:0] w);
      @(negedge clk);
      cw_we    = 1'b1;
      cw_wdata = w;
      @(negedge clk);
      cw_we    = 1'b0;
   endtask

   // Monitor: pops one expected item per acknowledge rise
   always @(negedge clk) begin
      if (rst_n) begin
         if (cw_rdata[26] && !prev_ack) begin
            if (sbq.size() == 0) begin
               checks++;
               fails++;
               $display("FAIL R8: unexpected acknowledge got 1 expected 0");
            end else begin
               mon_it = sbq.pop_front();
               check({mon_it.tag, " latency R3"}, cyc, mon_it.exp_cyc);
               if (mon_it.is_rd)
                  check({mon_it.tag, " data R5"}, {24'h0, cw_rdata[23:16]}, {24'h0, mon_it.exp});
            end
         end
         prev_ack = cw_rdata[26];
      end
   end

   task automatic start_txn(bit wr, bit rd, logic [5:0] a, logic [7:0] d, string tag);
      item_t it;
      int    start;
      bus_wr(word(1'b0, 1'b0, a, d));
      bus_wr(word(wr, rd, a, d));
      start = cyc;
      check({tag, " fields R2"}, cw_rdata, word(wr, rd, a, d) | {8'h00, last_rd, 16'h0000});
      it.is_rd   = rd && !wr;
      it.exp     = model[a];
      it.exp_cyc = start + 1 + ACK;
      it.tag     = tag;
      sbq.push_back(it);
      if (wr) model[a] = d;
      else    last_rd  = model[a];
   endtask

   task automatic finish_txn(logic [5:0] a, logic [7:0] d, string tag);
      int n = 0;
      while (!cw_rdata[26] && n < 200) begin
         @(negedge clk);
         n++;
      end
      check({tag, " ack seen R3"}, {31'h0, cw_rdata[26]}, 32'h1);
      repeat (2) @(negedge clk);
      check({tag, " ack held R3"}, {31'h0, cw_rdata[26]}, 32'h1);
      bus_wr(word(1'b0, 1'b0, a, d));
      check({tag, " ack before drop R6"}, {31'h0, cw_rdata[26]}, 32'h1);
      @(negedge clk);
      check({tag, " ack dropped R6"}, {31'h0, cw_rdata[26]}, 32'h0);
   endtask

   task automatic txn(bit wr, bit rd, logic [5:0] a, logic [7:0] d, string tag);
      start_txn(wr, rd, a, d, tag);
      finish_txn(a, d, tag);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
      $finish;
   end

   initial begin
      for (int i = 0; i < 64; i++) model[i] = 8'h00;
      last_rd = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 control word after reset", cw_rdata, 32'h0);

      // R1: bank empty after reset
      txn(1'b0, 1'b1, 6'h0D, 8'h00, "R1 bank reset read");

      // R4/R5 basic write then read back
      txn(1'b1, 1'b0, 6'h07, 8'hA5, "R4 write 07");
      txn(1'b0, 1'b1, 6'h07, 8'h00, "R5 read 07");

      // R4: delay register set 0x00..0x08 and 0x0B..0x0D
      for (int i = 0; i < 12; i++) begin
         logic [5:0] a = (i < 9) ? 6'(i) : 6'(i + 2);
         txn(1'b1, 1'b0, a, 8'(a * 37 + 11), "R4 delay write");
      end
      for (int i = 0; i < 12; i++) begin
         logic [5:0] a = (i < 9) ? 6'(i) : 6'(i + 2);
         txn(1'b0, 1'b1, a, 8'h00, "R5 delay read");
      end

      // R7: fields rewritten while request pending are not used
      start_txn(1'b1, 1'b0, 6'h02, 8'h11, "R7 held write");
      bus_wr(word(1'b1, 1'b0, 6'h03, 8'h99));
      finish_txn(6'h03, 8'h99, "R7 held write");
      txn(1'b0, 1'b1, 6'h02, 8'h00, "R7 read target");
      txn(1'b0, 1'b1, 6'h03, 8'h00, "R7 read neighbour");

      // R8: request withdrawn before acknowledge
      bus_wr(word(1'b0, 1'b0, 6'h05, 8'hEE));
      bus_wr(word(1'b1, 1'b0, 6'h05, 8'hEE));
      bus_wr(word(1'b0, 1'b0, 6'h05, 8'hEE));
      repeat (12) @(negedge clk);
      check("R8 no ack after abort", {31'h0, cw_rdata[26]}, 32'h0);
      txn(1'b0, 1'b1, 6'h05, 8'h00, "R8 bank untouched");

      // R9: both requests act as a write, read field kept
      txn(1'b1, 1'b1, 6'h0C, 8'h3C, "R9 dual request");
      check("R9 read field kept", {24'h0, cw_rdata[23:16]}, {24'h0, last_rd});
      txn(1'b0, 1'b1, 6'h0C, 8'h00, "R9 read after dual");

      // R2: unused bits written as 1 read back as 0
      bus_wr(32'hF800_00C0 | word(1'b0, 1'b0, 6'h2A, 8'h5C));
      check("R2 unused bits", cw_rdata, word(1'b0, 1'b0, 6'h2A, 8'h5C) | {8'h00, last_rd, 16'h0000});

      repeat (4) @(negedge clk);
      check("R3 scoreboard drained", sbq.size(), 32'h0);
      report();
      $finish;
   end
endmodule